// File: doc/BRIEF.md
# Serial Panel Register Write Sequencer

This block turns register writes for a display controller into traffic on a four-wire serial link in clock-idle-high mode. A host hands over an 8-bit register number and a 16-bit value with a valid/ready handshake. Each write goes out as two separate 24-bit frames, and chip select rises between them. The first frame selects the register: the index prefix byte 0x74, then a zero byte, then the register number. The second frame carries the data: the data prefix byte 0x76, then the value's upper byte, then its lower byte.

Two built-in commands cover panel bring-up and power-down. A one-cycle start-up trigger writes the power register to "on" and then writes the output-control register with a scan/colour mode chosen at the pins. A one-cycle shutdown trigger writes the power register to "off". The serial clock is derived from the core clock by a fixed half-period divider. The read line from the panel is accepted but never used.

Top module: `panel_spi_wr_seq`

## Requirements
- R1: After reset, chip select is high, the serial clock is high, the data line is low and `req_ready` is high.
- R2: The serial clock idles high and is high whenever chip select is high. Each bit lasts `2*HALF_DIV` core cycles: a low half, then a high half whose rising edge samples the bit. While chip select is low, the data line changes only when the clock falls.
- R3: A host write sends two 24-bit frames, most significant bit first. The first frame is {0x74, 0x00, index} and the second is {0x76, value[15:8], value[7:0]}.
- R4: Chip select is low for exactly one frame: `HALF_DIV` cycles before the first falling clock edge, 48 bit halves, then `HALF_DIV` cycles of hold. It then stays high for at least `2*HALF_DIV` cycles before the next frame. Chip select first falls two cycles after the accepting edge.
- R5: `req_ready` is high only while the block is idle and neither trigger is high. A request is taken on an edge with `req_valid` and `req_ready` both high. `req_ready` stays low from that edge until the edge after the last frame's chip-select gap ends.
- R6: A start-up trigger writes register 0x11 with 0x0000, then register 0x01 with 0x00EF OR the mode bits. `boot_mode[0]` maps to bit 8 (left-to-right scan), `boot_mode[1]` to bit 9 (top-to-bottom), `boot_mode[2]` to bit 11 (BGR order) and `boot_mode[3]` to bit 13 (normal output). The mode is taken on the accepting edge.
- R7: A shutdown trigger writes register 0x11 with 0x0001.
- R8: When more than one command is presented in the same idle cycle, shutdown wins over start-up and start-up wins over a host request. The losing commands are dropped. Triggers that arrive while the block is busy have no effect.
- R9: `spi_miso` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host write request valid |
| req_ready | output | 1 | Block can take a host request this cycle |
| req_index | input | 8 | Target register number |
| req_value | input | 16 | Value to write |
| boot_go | input | 1 | One-cycle start-up sequence trigger |
| boot_mode | input | 4 | Scan/colour mode bits for the start-up output-control write |
| shut_go | input | 1 | One-cycle shutdown trigger |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the panel |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_miso | input | 1 | Serial data from the panel, unused |

## Verification
The two functions that can meet in one cycle are command arbitration and the host handshake. A trigger and a host request can both be presented on the same idle edge, and the trigger then has to take the slot while `req_ready` drops in that same cycle. The bench raises shutdown, start-up and a host request together, then start-up and a host request together. It also fires triggers in the middle of a busy write. Each cycle, a behavioural timeline model is compared against `req_ready` and the three serial pins. Every frame is also decoded on rising clock edges and matched against the frame list the winning command should produce.

// File: rtl/pnl_spi_pkg.sv
package pnl_spi_pkg;

    localparam int FRAME_BITS   = 24;
    localparam int PH_LAST_BIT  = 2 * FRAME_BITS;      // last high half of the last bit
    localparam int PH_HOLD      = PH_LAST_BIT + 1;     // select held after last rising edge
    localparam int PH_GAP0      = PH_HOLD + 1;         // first deselected phase
    localparam int GAP_PHASES   = 2;                   // one full serial clock period
    localparam int NUM_PH       = PH_GAP0 + GAP_PHASES;
    localparam int PH_W         = $clog2(NUM_PH);
    localparam int MAX_WR       = 2;                   // longest built-in command
    localparam int WSEL_W       = (MAX_WR > 1) ? $clog2(MAX_WR) : 1;

    localparam logic [7:0]  SEL_PREFIX   = 8'h74;
    localparam logic [7:0]  DAT_PREFIX   = 8'h76;
    localparam logic [7:0]  REG_POWER    = 8'h11;
    localparam logic [7:0]  REG_OUTCTL   = 8'h01;
    localparam logic [15:0] POWER_ON     = 16'h0000;
    localparam logic [15:0] POWER_OFF    = 16'h0001;
    localparam logic [15:0] OUTCTL_BASE  = 16'h2AEF;

    typedef struct packed {
        logic [7:0]  idx;
        logic [15:0] val;
    } pnl_wr_t;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_HOST,
        CMD_BOOT,
        CMD_SHUT
    } pnl_cmd_e;

    function automatic logic [15:0] mode_bits(input logic [3:0] mode);
        logic [15:0] m;
        m       = '0;
        m[8]    = mode[0];
        m[9]    = mode[1];
        m[11]   = mode[2];
        m[13]   = mode[3];
        return m;
    endfunction

    function automatic logic [15:0] outctl_value(input logic [3:0] mode);
        return (OUTCTL_BASE & ~mode_bits(4'hF)) | mode_bits(mode);
    endfunction

    function automatic logic [FRAME_BITS-1:0] sel_frame(input pnl_wr_t w);
        return {SEL_PREFIX, 8'h00, w.idx};
    endfunction

    function automatic logic [FRAME_BITS-1:0] dat_frame(input pnl_wr_t w);
        return {DAT_PREFIX, w.val};
    endfunction

endpackage

// File: rtl/pnl_spi_engine.sv
module pnl_spi_engine
    import pnl_spi_pkg::*;
#(
    parameter int HALF_DIV = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame,
    output logic                  last,
    output logic                  sclk,
    output logic                  mosi,
    output logic                  cs_n
);

    localparam int HC_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic                  active;
    logic [PH_W-1:0]       ph;
    logic [HC_W-1:0]       hc;
    logic [FRAME_BITS-1:0] sh;
    logic                  ph_end;
    logic                  shift_now;
    logic                  cs_d, sclk_d, mosi_d;

    assign ph_end    = (hc == HC_W'(HALF_DIV - 1));
    assign last      = active && ph_end && (ph == PH_W'(NUM_PH - 1));
    // move to the next bit when leaving a high half that is not the last one
    assign shift_now = !ph[0] && (ph >= PH_W'(2)) && (ph <= PH_W'(PH_LAST_BIT - 2));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            ph     <= '0;
            hc     <= '0;
            sh     <= '0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                ph     <= '0;
                hc     <= '0;
                sh     <= frame;
            end
        end else if (ph_end) begin
            hc <= '0;
            if (ph == PH_W'(NUM_PH - 1)) begin
                active <= 1'b0;
            end else begin
                ph <= ph + 1'b1;
            end
            if (shift_now) begin
                sh <= {sh[FRAME_BITS-2:0], 1'b0};
            end
        end else begin
            hc <= hc + 1'b1;
        end
    end

    always_comb begin
        cs_d   = !(active && (ph < PH_W'(PH_GAP0)));
        sclk_d = !(active && ph[0] && (ph <= PH_W'(PH_LAST_BIT)));
        mosi_d = active && (ph != '0) && (ph <= PH_W'(PH_HOLD)) && sh[FRAME_BITS-1];
    end

    // registered pin drivers
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n <= 1'b1;
            sclk <= 1'b1;
            mosi <= 1'b0;
        end else begin
            cs_n <= cs_d;
            sclk <= sclk_d;
            mosi <= mosi_d;
        end
    end

endmodule

// File: rtl/pnl_cmd_seq.sv
module pnl_cmd_seq
    import pnl_spi_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_valid,
    input  pnl_wr_t               host_wr,
    input  logic                  boot_go,
    input  logic [3:0]            boot_mode,
    input  logic                  shut_go,
    input  logic                  eng_last,
    output logic                  host_ready,
    output logic                  eng_start,
    output logic [FRAME_BITS-1:0] eng_frame
);

    logic              busy;
    logic              go;
    logic              fsel;          // 0: register-select frame, 1: data frame
    logic [WSEL_W-1:0] wsel;
    logic [WSEL_W-1:0] wlast;
    pnl_wr_t           wr_q [MAX_WR];
    pnl_cmd_e          cmd;

    always_comb begin
        cmd = CMD_NONE;
        if (!busy) begin
            if (shut_go)         cmd = CMD_SHUT;
            else if (boot_go)    cmd = CMD_BOOT;
            else if (host_valid) cmd = CMD_HOST;
        end
    end

    assign host_ready = !busy && !shut_go && !boot_go;
    assign eng_start  = go;
    assign eng_frame  = fsel ? dat_frame(wr_q[wsel]) : sel_frame(wr_q[wsel]);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            go    <= 1'b0;
            fsel  <= 1'b0;
            wsel  <= '0;
            wlast <= '0;
            for (int i = 0; i < MAX_WR; i++) wr_q[i] <= '0;
        end else begin
            go <= 1'b0;
            if (cmd != CMD_NONE) begin
                busy <= 1'b1;
                go   <= 1'b1;
                fsel <= 1'b0;
                wsel <= '0;
                unique case (cmd)
                    CMD_SHUT: begin
                        wr_q[0] <= '{idx: REG_POWER, val: POWER_OFF};
                        wlast   <= '0;
                    end
                    CMD_BOOT: begin
                        wr_q[0] <= '{idx: REG_POWER,  val: POWER_ON};
                        wr_q[1] <= '{idx: REG_OUTCTL, val: outctl_value(boot_mode)};
                        wlast   <= WSEL_W'(1);
                    end
                    default: begin
                        wr_q[0] <= host_wr;
                        wlast   <= '0;
                    end
                endcase
            end else if (busy && eng_last) begin
                if (!fsel) begin
                    fsel <= 1'b1;
                    go   <= 1'b1;
                end else if (wsel == wlast) begin
                    busy <= 1'b0;
                end else begin
                    wsel <= wsel + 1'b1;
                    fsel <= 1'b0;
                    go   <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/panel_spi_wr_seq.sv
module panel_spi_wr_seq
    import pnl_spi_pkg::*;
#(
    parameter int HALF_DIV = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [7:0]  req_index,
    input  logic [15:0] req_value,
    input  logic        boot_go,
    input  logic [3:0]  boot_mode,
    input  logic        shut_go,
    output logic        spi_sclk,
    output logic        spi_mosi,
    output logic        spi_cs_n,
    input  logic        spi_miso
);

    pnl_wr_t               host_wr;
    logic                  eng_start;
    logic                  eng_last;
    logic [FRAME_BITS-1:0] eng_frame;

    assign host_wr = '{idx: req_index, val: req_value};

    pnl_cmd_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .host_valid (req_valid),
        .host_wr    (host_wr),
        .boot_go    (boot_go),
        .boot_mode  (boot_mode),
        .shut_go    (shut_go),
        .eng_last   (eng_last),
        .host_ready (req_ready),
        .eng_start  (eng_start),
        .eng_frame  (eng_frame)
    );

    pnl_spi_engine #(
        .HALF_DIV (HALF_DIV)
    ) u_eng (
        .clk   (clk),
        .rst   (rst),
        .start (eng_start),
        .frame (eng_frame),
        .last  (eng_last),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .cs_n  (spi_cs_n)
    );

endmodule

// File: rtl/panel_spi_wr_seq_chk.sv
module panel_spi_wr_seq_chk #(
    parameter int HALF_DIV = 7
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic spi_cs_n,
    input logic spi_miso
);

    localparam int GAP_MIN = 2 * HALF_DIV;
    localparam int GW      = $clog2(GAP_MIN + 1);

    logic [GW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)                           hi_cnt <= GW'(GAP_MIN);
        else if (!spi_cs_n)                hi_cnt <= '0;
        else if (hi_cnt != GW'(GAP_MIN))   hi_cnt <= hi_cnt + 1'b1;
    end

    p_sclk_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> spi_sclk);

    p_mosi_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && spi_sclk && $past(!spi_cs_n && spi_sclk)) |-> $stable(spi_mosi));

    p_cs_gap_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> (hi_cnt == GW'(GAP_MIN)));

    p_busy_selected_r5: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> !req_ready);

    p_accept_drops_ready_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_mosi_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && spi_miso) |-> !spi_mosi);

endmodule

bind panel_spi_wr_seq panel_spi_wr_seq_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_cs_n  (spi_cs_n),
    .spi_miso  (spi_miso)
);

// File: tb/panel_spi_wr_seq_tb.sv
module panel_spi_wr_seq_tb;

    localparam int H    = 7;           // 250 MHz core, serial clock about 17.9 MHz
    localparam int FR   = 52 * H;      // cycles per frame including gap
    localparam int SLOT = FR + 1;      // one idle cycle before the next frame

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_index = '0;
    logic [15:0] req_value = '0;
    logic        boot_go = 1'b0;
    logic [3:0]  boot_mode = '0;
    logic        shut_go = 1'b0;
    logic        spi_sclk, spi_mosi, spi_cs_n;
    logic        spi_miso = 1'b0;

    always #2 clk = ~clk;   // 4 time-unit period

    panel_spi_wr_seq #(.HALF_DIV(H)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_index(req_index), .req_value(req_value), .boot_go(boot_go),
        .boot_mode(boot_mode), .shut_go(shut_go), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    done  = 1'b0;
    bit    miso_noise = 1'b0;
    string scen  = "R1";

    // behavioural model state
    bit          m_busy = 1'b0;
    int          m_n    = 0;
    int          m_nf   = 0;
    logic [23:0] m_fr [4];
    logic [23:0] cap_exp [$];

    function automatic logic [23:0] f_sel(input logic [7:0] idx);
        return {8'h74, 8'h00, idx};
    endfunction

    function automatic logic [23:0] f_dat(input logic [15:0] v);
        return {8'h76, v[15:8], v[7:0]};
    endfunction

    function automatic logic [15:0] boot_val(input logic [3:0] md);
        logic [15:0] v;
        v = 16'h00EF;
        if (md[0]) v = v | 16'h0100;
        if (md[1]) v = v | 16'h0200;
        if (md[2]) v = v | 16'h0800;
        if (md[3]) v = v | 16'h2000;
        return v;
    endfunction

    function automatic void add_fr(input logic [23:0] f);
        m_fr[m_nf] = f;
        m_nf++;
        cap_exp.push_back(f);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_busy = 1'b0;
            m_n    = 0;
        end else if (m_busy) begin
            m_n++;
            if (m_n == m_nf * SLOT) m_busy = 1'b0;
        end else if (shut_go || boot_go || req_valid) begin
            m_nf = 0;
            m_n  = 0;
            m_busy = 1'b1;
            if (shut_go) begin
                add_fr(f_sel(8'h11)); add_fr(f_dat(16'h0001));
            end else if (boot_go) begin
                add_fr(f_sel(8'h11)); add_fr(f_dat(16'h0000));
                add_fr(f_sel(8'h01)); add_fr(f_dat(boot_val(boot_mode)));
            end else begin
                add_fr(f_sel(req_index)); add_fr(f_dat(req_value));
            end
        end
    end

    task automatic chk(input string tag, input string sig, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s (scenario %s) cycle %0d %s got %b expected %b",
                     tag, scen, cyc, sig, got, exp);
        end
    endtask

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic e_cs, e_sclk, e_mosi, e_rdy;
            e_cs = 1'b1; e_sclk = 1'b1; e_mosi = 1'b0;
            if (m_busy && m_n >= 2) begin
                int pos, f, k, ph, b;
                pos = m_n - 2;
                f = pos / SLOT;
                k = pos % SLOT;
                if (f < m_nf && k < FR) begin
                    ph = k / H;
                    if (ph < 50) e_cs = 1'b0;
                    if (ph >= 1 && ph <= 48 && (ph % 2) == 1) e_sclk = 1'b0;
                    if (ph >= 1 && ph <= 49) begin
                        b = (ph - 1) / 2;
                        if (b > 23) b = 23;
                        e_mosi = m_fr[f][23 - b];
                    end
                end
            end
            e_rdy = !m_busy && !shut_go && !boot_go;
            chk("R4", "spi_cs_n", spi_cs_n, e_cs);
            chk("R2", "spi_sclk", spi_sclk, e_sclk);
            chk("R3", "spi_mosi", spi_mosi, e_mosi);
            chk("R5", "req_ready", req_ready, e_rdy);
        end
    end

    // frame decoder on rising serial clock
    logic [23:0] cap_sh = '0;
    int          cap_n  = 0;
    bit          cap_on = 1'b0;

    always @(negedge spi_cs_n) begin
        cap_n  = 0;
        cap_on = 1'b1;
    end

    always @(posedge spi_sclk) begin
        if (spi_cs_n === 1'b0) begin
            cap_sh = {cap_sh[22:0], spi_mosi};
            cap_n++;
        end
    end

    always @(posedge spi_cs_n) begin
        if (cap_on) begin
            logic [23:0] e;
            cap_on = 1'b0;
            e = (cap_exp.size() > 0) ? cap_exp.pop_front() : 24'hxxxxxx;
            n_cmp++;
            if (cap_n != 24 || cap_sh !== e) begin
                n_bad++;
                $display("FAIL %s frame decode: got %0d bits %h expected 24 bits %h",
                         scen, cap_n, cap_sh, e);
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk); #1;
            if (miso_noise) spi_miso = 1'($urandom() & 1);
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (m_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse(input bit v, input bit b, input bit s,
                         input logic [7:0] idx, input logic [15:0] val, input logic [3:0] md);
        @(posedge clk); #1;
        req_valid = v; boot_go = b; shut_go = s;
        req_index = idx; req_value = val; boot_mode = md;
        @(posedge clk); #1;
        req_valid = 1'b0; boot_go = 1'b0; shut_go = 1'b0;
        boot_mode = 4'h0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        scen = "R1";
        chk("R1", "spi_cs_n", spi_cs_n, 1'b1);
        chk("R1", "spi_sclk", spi_sclk, 1'b1);
        chk("R1", "spi_mosi", spi_mosi, 1'b0);
        chk("R1", "req_ready", req_ready, 1'b1);

        scen = "R3";
        pulse(1, 0, 0, 8'h5A, 16'hC3A5, 4'h0);
        wait_idle();
        pulse(1, 0, 0, 8'hFF, 16'h0000, 4'h0);
        wait_idle();

        scen = "R9";
        miso_noise = 1'b1;
        pulse(1, 0, 0, 8'h01, 16'h8001, 4'h0);
        wait_idle();
        miso_noise = 1'b0;

        scen = "R6";
        pulse(0, 1, 0, 8'h00, 16'h0000, 4'b1011);
        wait_idle();
        pulse(0, 1, 0, 8'h00, 16'h0000, 4'b0000);
        wait_idle();

        scen = "R7";
        pulse(0, 0, 1, 8'h00, 16'h0000, 4'h0);
        wait_idle();

        scen = "R8";
        pulse(1, 1, 1, 8'h33, 16'h1234, 4'hF);
        repeat (200) @(posedge clk);
        pulse(1, 1, 0, 8'h44, 16'h5678, 4'h5);
        wait_idle();
        pulse(1, 1, 0, 8'h44, 16'h5678, 4'b0100);
        repeat (900) @(posedge clk);
        pulse(1, 0, 1, 8'h66, 16'h9ABC, 4'h0);
        wait_idle();

        scen = "R5";
        @(posedge clk); #1;
        req_valid = 1'b1; req_index = 8'hA5; req_value = 16'h5AA5;
        @(negedge clk);
        while (m_busy || m_nf == 0) @(negedge clk);
        @(negedge clk);
        while (m_busy) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 1'b0;
        wait_idle();

        n_cmp++;
        if (cap_exp.size() != 0) begin
            n_bad++;
            $display("FAIL R3 frames missing: got %0d left expected 0", cap_exp.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got no completion expected completion");
            summary();
            $finish;
        end
    end

endmodule